// File: doc/BRIEF.md
# Pin Port with Programmable Event Interrupts

This block runs one general-purpose I/O channel of up to sixteen pins and exposes it through a small memory-mapped register set of 32-bit words. Software sets each pin's direction and output value. It can read the synchronized level of every pin at any time.

Each pin can also report an event. Software picks a trigger for each pin: falling edge, rising edge, either edge, low level or high level. An event on an enabled pin sets that pin's pending bit in a read-only status word. An edge event stays pending until software writes a one to the clear word. A level event keeps setting the bit for as long as the level is present. Masking is controlled through two write-one words, one that sets mask bits and one that clears them. A single interrupt line is asserted whenever some pin is pending, enabled and unmasked.

A soft-reset word returns every register to its default while its bit is one. Writing one and then zero restarts the channel from defaults.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset: all trigger codes are 000 (falling edge), enables are 0, mask bits are 1, output bits are 0, every pin is an input (`pin_oe` = 0), status is 0 and `irq` is 0.
- R2: Word 0x00 holds the output bits and word 0x04 the direction bits. A direction bit of 1 drives `pin_out` of that pin as output (`pin_oe` = 1). Only the low NPINS bits are stored, and the upper bits read as 0.
- R3: Word 0x08 reads the pin inputs after a two-flop synchronizer, so a change on `pin_in` is visible in that word after two clock edges.
- R4: A pin's 3-bit trigger code sits at bits 4*i+2..4*i of word 0x20 for pins 0-7, and at bits 4*(i-8)+2..4*(i-8) of word 0x24 for pins 8-15. Bit 3 of each slot reads 0. The codes are: 000 falling edge, 001 rising edge, 010 low level, 011 high level, and bit 2 set means both edges.
- R5: On an edge trigger, the status bit (word 0x10) stays set until a 1 is written to the same bit of the clear word 0x14. Zero bits written to 0x14 do nothing.
- R6: On a level trigger, the status bit is set again every cycle while the level is present, so a clear has no lasting effect until the level goes away.
- R7: With bit 2 of the code set, both a rising and a falling transition set the status bit.
- R8: A pin whose enable bit (word 0x0C, read/write) is 0 never sets its status bit and never raises `irq`.
- R9: Writing 1s to word 0x18 sets those mask bits, and writing 1s to word 0x1C clears them. Zero bits leave the mask unchanged. Reading word 0x18 returns the mask.
- R10: `irq` is the OR over pins of status AND enable AND NOT mask. The status bit still latches while its pin is masked.
- R11: Writing 1 and then 0 to bit 0 of word 0x28 returns every register and the status to its R1 value.
- R12: Writes to the status word 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 6 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Pin input levels, asynchronous |
| pin_out | output | NPINS | Output levels from the output word |
| pin_oe | output | NPINS | Output enables from the direction word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets a level trigger that is cleared while its level is still present. A design that treated levels like edges would drop the status bit and lose the event. It writes zero bits to the clear, mask-set and mask-clear words, which would corrupt neighbouring pins if the design wrote the full word instead of updating only the selected bits. It checks that a masked pin still latches its status and raises `irq` as soon as it is unmasked, so a design that gated the status itself with the mask would miss a pending event. It also checks pins 8-15, whose codes sit in the second mode word at a slot offset of pin-8, where an off-by-one slot shows up as the wrong pin responding.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned SLOT_W  = 4;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned SLOTS   = BUS_W / SLOT_W;

  localparam logic [ADDR_W-1:0] OFS_DOUT    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PIN     = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN     = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ICLR    = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_MSET    = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MCLR    = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_MODE_LO = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MODE_HI = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_SRST    = 6'h28;

  // low two bits of a trigger code; bit 2 selects both edges
  typedef enum logic [1:0] {
    TRG_FALL = 2'b00,
    TRG_RISE = 2'b01,
    TRG_LOW  = 2'b10,
    TRG_HIGH = 2'b11
  } trig_base_e;
endpackage

// File: rtl/gpio_evt_sync.sv
`timescale 1ns/1ps
module gpio_evt_sync #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_sync
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        stab_q <= meta_q;
      end
    end
    assign pin_sync[i] = stab_q;
  end
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    srst,
  input  logic [NPINS-1:0]        pin_sync,
  input  logic [NPINS*CODE_W-1:0] mode,
  input  logic [NPINS-1:0]        ien,
  input  logic [NPINS-1:0]        iclr,
  output logic [NPINS-1:0]        status
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] status_d, status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_trig
    logic [CODE_W-1:0] code;
    logic rise, fall;
    assign code = mode[CODE_W*i +: CODE_W];
    assign rise = pin_sync[i] & ~prev_q[i];
    assign fall = ~pin_sync[i] & prev_q[i];
    always_comb begin
      if (code[2]) begin
        hit[i] = rise | fall;
      end else begin
        case (trig_base_e'(code[1:0]))
          TRG_FALL: hit[i] = fall;
          TRG_RISE: hit[i] = rise;
          TRG_LOW:  hit[i] = ~pin_sync[i];
          TRG_HIGH: hit[i] = pin_sync[i];
          default:  hit[i] = 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    if (srst) status_d = '0;
    else      status_d = (status_q & ~iclr) | (hit & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_evt_regs.sv
`timescale 1ns/1ps
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  input  logic [NPINS-1:0]        pin_sync,
  input  logic [NPINS-1:0]        status,
  output logic [NPINS-1:0]        dout,
  output logic [NPINS-1:0]        dir,
  output logic [NPINS-1:0]        ien,
  output logic [NPINS-1:0]        mask,
  output logic [NPINS*CODE_W-1:0] mode,
  output logic                    srst,
  output logic [NPINS-1:0]        iclr
);
  localparam int unsigned PAD = BUS_W - NPINS;

  logic [NPINS-1:0]        dout_d, dout_q, dir_d, dir_q, ien_d, ien_q, mask_d, mask_q;
  logic [NPINS*CODE_W-1:0] mode_d, mode_q;
  logic                    srst_d, srst_q;
  logic                    reg_en;
  logic [NPINS-1:0]        wd;
  logic [BUS_W-1:0]        mode_lo_rd, mode_hi_rd;
  logic                    unused_wdata;

  assign wd           = bus_wdata[NPINS-1:0];
  assign unused_wdata = ^bus_wdata;
  assign reg_en       = bus_wr | srst_q;

  always_comb begin
    dout_d = dout_q;
    dir_d  = dir_q;
    ien_d  = ien_q;
    mask_d = mask_q;
    mode_d = mode_q;
    srst_d = srst_q;
    if (bus_wr) begin
      case (bus_addr)
        OFS_DOUT: dout_d = wd;
        OFS_DIR:  dir_d  = wd;
        OFS_IEN:  ien_d  = wd;
        OFS_MSET: mask_d = mask_q | wd;
        OFS_MCLR: mask_d = mask_q & ~wd;
        OFS_SRST: srst_d = bus_wdata[0];
        default:  ;
      endcase
      for (int i = 0; i < NPINS; i++) begin
        if (bus_addr == ((i < SLOTS) ? OFS_MODE_LO : OFS_MODE_HI))
          mode_d[CODE_W*i +: CODE_W] = bus_wdata[SLOT_W*(i % SLOTS) +: CODE_W];
      end
    end
    if (srst_q) begin
      dout_d = '0;
      dir_d  = '0;
      ien_d  = '0;
      mask_d = '1;
      mode_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      mask_q <= '1;
      mode_q <= '0;
      srst_q <= 1'b0;
    end else if (reg_en) begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
      mask_q <= mask_d;
      mode_q <= mode_d;
      srst_q <= srst_d;
    end
  end

  // one-cycle clear request toward the detector
  assign iclr = (bus_wr && bus_addr == OFS_ICLR && !srst_q) ? wd : '0;

  always_comb begin
    mode_lo_rd = '0;
    mode_hi_rd = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (i < SLOTS) mode_lo_rd[SLOT_W*(i % SLOTS) +: CODE_W] = mode_q[CODE_W*i +: CODE_W];
      else           mode_hi_rd[SLOT_W*(i % SLOTS) +: CODE_W] = mode_q[CODE_W*i +: CODE_W];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DOUT:    bus_rdata = {{PAD{1'b0}}, dout_q};
      OFS_DIR:     bus_rdata = {{PAD{1'b0}}, dir_q};
      OFS_PIN:     bus_rdata = {{PAD{1'b0}}, pin_sync};
      OFS_IEN:     bus_rdata = {{PAD{1'b0}}, ien_q};
      OFS_STAT:    bus_rdata = {{PAD{1'b0}}, status};
      OFS_MSET:    bus_rdata = {{PAD{1'b0}}, mask_q};
      OFS_MODE_LO: bus_rdata = mode_lo_rd;
      OFS_MODE_HI: bus_rdata = mode_hi_rd;
      OFS_SRST:    bus_rdata = {{(BUS_W-1){1'b0}}, srst_q};
      default:     bus_rdata = '0;
    endcase
  end

  assign dout = dout_q;
  assign dir  = dir_q;
  assign ien  = ien_q;
  assign mask = mask_q;
  assign mode = mode_q;
  assign srst = srst_q;
endmodule

// File: rtl/gpio_evt_port.sv
`timescale 1ns/1ps
module gpio_evt_port
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic [NPINS-1:0]        pin_sync, status_q, ien_q, mask_q, iclr;
  logic [NPINS*CODE_W-1:0] mode_q;
  logic                    srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  gpio_evt_sync #(.NPINS(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  gpio_evt_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .status    (status_q),
    .dout      (pin_out),
    .dir       (pin_oe),
    .ien       (ien_q),
    .mask      (mask_q),
    .mode      (mode_q),
    .srst      (srst_q),
    .iclr      (iclr)
  );

  gpio_evt_detect #(.NPINS(NPINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .srst     (srst_q),
    .pin_sync (pin_sync),
    .mode     (mode_q),
    .ien      (ien_q),
    .iclr     (iclr),
    .status   (status_q)
  );

  assign irq = |(status_q & ien_q & ~mask_q);
endmodule

// File: rtl/gpio_evt_port_chk.sv
`timescale 1ns/1ps
module gpio_evt_port_chk #(
  parameter int unsigned NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [5:0]       bus_addr,
  input logic [NPINS-1:0] wd,
  input logic             irq,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] ien,
  input logic [NPINS-1:0] mask,
  input logic             srst
);
  // R8: a disabled pin never gains a status bit
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(ien)) == '0));

  // R9: mask-set write sets every selected bit
  a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 6'h18) |=> ((mask & $past(wd)) == $past(wd)));

  // R9: mask-clear write clears every selected bit
  a_r9_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 6'h1C && !srst) |=> ((mask & $past(wd)) == '0));

  // R10: the interrupt needs at least one enabled pin
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ien));

  // R11: soft reset drives state to defaults
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (status == '0 && ien == '0 && mask == '1));
endmodule

bind gpio_evt_port gpio_evt_port_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wd       (bus_wdata[NPINS-1:0]),
  .irq      (irq),
  .status   (status_q),
  .ien      (ien_q),
  .mask     (mask_q),
  .srst     (srst_q)
);

// File: tb/gpio_evt_port_bench.sv
`timescale 1ns/1ps
module gpio_evt_port_bench;
  localparam int N = 16;
  localparam logic [5:0] A_DOUT = 6'h00, A_DIR = 6'h04, A_PIN = 6'h08, A_IEN = 6'h0C,
    A_STAT = 6'h10, A_ICLR = 6'h14, A_MSET = 6'h18, A_MCLR = 6'h1C,
    A_MLO = 6'h20, A_MHI = 6'h24, A_SRST = 6'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_lo, m_hi;
  logic [N-1:0] m_ien, m_mask, m_stat, cur;

  always #4 clk = ~clk;

  gpio_evt_port #(.NPINS(N)) u_gpio_evt_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(input int p);
    return (p < 8) ? m_lo[4*p +: 3] : m_hi[4*(p-8) +: 3];
  endfunction

  function automatic logic [N-1:0] lvl_hit(input logic [N-1:0] v);
    logic [N-1:0] r = '0;
    for (int p = 0; p < N; p++) begin
      logic [2:0] c = code_of(p);
      if (!c[2] && c[1:0] == 2'b10) r[p] = ~v[p];
      if (!c[2] && c[1:0] == 2'b11) r[p] = v[p];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] edge_hit(input logic [N-1:0] o, input logic [N-1:0] n);
    logic [N-1:0] r = '0;
    for (int p = 0; p < N; p++) begin
      logic [2:0] c = code_of(p);
      logic up = n[p] & ~o[p];
      logic dn = o[p] & ~n[p];
      if (c[2]) r[p] = up | dn;
      else if (c[1:0] == 2'b00) r[p] = dn;
      else if (c[1:0] == 2'b01) r[p] = up;
    end
    return r;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_lo(input logic [31:0] v);
    wr(A_MLO, v); m_lo = v & 32'h7777_7777; m_stat |= m_ien & lvl_hit(cur);
  endtask
  task automatic set_hi(input logic [31:0] v);
    wr(A_MHI, v); m_hi = v & 32'h7777_7777; m_stat |= m_ien & lvl_hit(cur);
  endtask
  task automatic set_ien(input logic [N-1:0] v);
    wr(A_IEN, {16'h0, v}); m_ien = v; m_stat |= m_ien & lvl_hit(cur);
  endtask
  task automatic mset(input logic [N-1:0] v);
    wr(A_MSET, {16'h0, v}); m_mask |= v;
  endtask
  task automatic mclr(input logic [N-1:0] v);
    wr(A_MCLR, {16'h0, v}); m_mask &= ~v;
  endtask
  task automatic iclr(input logic [N-1:0] v);
    wr(A_ICLR, {16'h0, v}); m_stat = (m_stat & ~v) | (m_ien & lvl_hit(cur));
  endtask
  task automatic drive(input logic [N-1:0] n);
    @(negedge clk);
    pin_in = n;
    wait_cyc(4);
    m_stat |= m_ien & (edge_hit(cur, n) | lvl_hit(n));
    cur = n;
  endtask

  task automatic chk_evt(input string req);
    logic [31:0] d;
    rd(A_STAT, d);
    chk({req, " status"}, d, {16'h0, m_stat});
    chk({req, " irq"}, {31'h0, irq}, {31'h0, |(m_stat & m_ien & ~m_mask)});
  endtask

  task automatic chk_defaults(input string req);
    logic [31:0] d;
    rd(A_DOUT, d); chk({req, " dout"}, d, 32'h0);
    rd(A_DIR, d);  chk({req, " dir"}, d, 32'h0);
    rd(A_IEN, d);  chk({req, " ien"}, d, 32'h0);
    rd(A_MSET, d); chk({req, " mask"}, d, 32'h0000_FFFF);
    rd(A_MLO, d);  chk({req, " mode lo"}, d, 32'h0);
    rd(A_MHI, d);  chk({req, " mode hi"}, d, 32'h0);
    rd(A_STAT, d); chk({req, " status"}, d, 32'h0);
    chk({req, " pin_oe"}, {16'h0, pin_oe}, 32'h0);
    chk({req, " pin_out"}, {16'h0, pin_out}, 32'h0);
    chk({req, " irq"}, {31'h0, irq}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;
    void'($urandom(32'h1F2E3D4C));
    m_lo = '0; m_hi = '0; m_ien = '0; m_mask = '1; m_stat = '0; cur = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);

    chk_defaults("R1");

    // R2: output and direction, upper bits dropped
    for (int k = 0; k < 8; k++) begin
      v = $urandom;
      wr(A_DOUT, v);
      d = $urandom;
      wr(A_DIR, d);
      rd(A_DOUT, bus_wdata);
      chk("R2 dout readback", bus_wdata, {16'h0, v[15:0]});
      chk("R2 pin_out", {16'h0, pin_out}, {16'h0, v[15:0]});
      chk("R2 pin_oe", {16'h0, pin_oe}, {16'h0, d[15:0]});
    end

    // R3: synchronized pin readback, two edges of delay
    for (int k = 0; k < 6; k++) begin
      v = $urandom;
      @(negedge clk) pin_in = v[15:0];
      @(posedge clk); @(negedge clk);
      rd(A_PIN, d);
      chk("R3 one edge only, old value", d, {16'h0, cur});
      @(posedge clk); @(negedge clk);
      rd(A_PIN, d);
      chk("R3 pin readback", d, {16'h0, v[15:0]});
      cur = v[15:0];
    end
    drive(16'h0000);

    // R4: mode slot readback
    v = $urandom;
    set_lo(v);
    rd(A_MLO, d); chk("R4 mode lo slots", d, v & 32'h7777_7777);
    v = $urandom;
    set_hi(v);
    rd(A_MHI, d); chk("R4 mode hi slots", d, v & 32'h7777_7777);
    set_lo(32'h0000_0001);
    set_hi(32'h0);

    // R5: rising edge on pin 0 latches until cleared
    set_ien(16'h0001);
    mclr(16'h0001);
    drive(16'h0001);
    chk_evt("R5 rise latched");
    chk("R5 status value", {16'h0, m_stat}, 32'h1);
    iclr(16'h0000);
    chk_evt("R5 zero clear no effect");
    iclr(16'h0001);
    chk_evt("R5 cleared");

    // R4: pin 3 default falling code
    set_ien(16'h0009);
    drive(16'h0009);
    chk_evt("R4 rise ignored on falling code");
    drive(16'h0001);
    chk_evt("R4 falling edge pin3");
    chk("R4 pin3 set", {16'h0, m_stat}, 32'h8);
    iclr(16'h0008);

    // R8: disabled pin 5
    set_ien(16'h0001);
    mclr(16'h0020);
    drive(16'h0021);
    drive(16'h0001);
    chk_evt("R8 disabled pin");
    chk("R8 no status", {16'h0, m_stat}, 32'h0);

    // R6: pin 9 high level in second mode word, slot 1
    set_hi(32'h0000_0030);
    set_ien(16'h0201);
    mclr(16'h0200);
    drive(16'h0201);
    chk_evt("R6 level set");
    iclr(16'h0200);
    chk_evt("R6 clear while level held");
    chk("R6 still pending", {16'h0, m_stat}, 32'h200);
    drive(16'h0001);
    iclr(16'h0200);
    chk_evt("R6 cleared after level gone");

    // R7: pin 15 both edges
    set_hi(32'h4000_0030);
    set_ien(16'h8201);
    mclr(16'h8000);
    drive(16'h8001);
    chk_evt("R7 rise");
    iclr(16'h8000);
    drive(16'h0001);
    chk_evt("R7 fall");
    chk("R7 pin15 set", {16'h0, m_stat}, 32'h8000);

    // R10: masked pin still latches, irq follows unmask
    iclr(16'h8000);
    mset(16'h8000);
    drive(16'h8001);
    chk_evt("R10 masked latch");
    chk("R10 irq low while masked", {31'h0, irq}, 32'h0);
    mclr(16'h8000);
    chk("R10 irq on unmask", {31'h0, irq}, 32'h1);

    // R9: mask set/clear with zero bits
    mset(16'h00F0);
    rd(A_MSET, d); chk("R9 mask set", d, {16'h0, m_mask});
    mclr(16'h0030);
    rd(A_MSET, d); chk("R9 mask clear", d, {16'h0, m_mask});

    // R12: status is read-only
    v = {16'h0, m_stat};
    wr(A_STAT, 32'h0000_FFFF);
    rd(A_STAT, d); chk("R12 status write ignored", d, v);

    // R11: soft reset
    wr(A_DOUT, 32'h1234); wr(A_DIR, 32'hFF00);
    wr(A_SRST, 32'h1);
    wr(A_SRST, 32'h0);
    m_lo = '0; m_hi = '0; m_ien = '0; m_mask = '1; m_stat = '0;
    chk_defaults("R11");

    // random mix against the model: R5/R6/R7/R10
    for (int k = 0; k < 60; k++) begin
      case ($urandom % 5)
        0: set_lo($urandom);
        1: set_hi($urandom);
        2: set_ien(16'($urandom));
        3: begin mset(16'($urandom)); mclr(16'($urandom)); end
        default: iclr(16'($urandom));
      endcase
      drive(16'($urandom));
      chk_evt("R5/R6/R7/R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule